// File: doc/BRIEF.md
# Scan Test Port Controller with Instruction Decode

This block is the test access port of a memory device. A sixteen-state controller, advanced on each rising edge of the test clock, decodes the mode-select line (`tms`). A 3-bit instruction register selects which data register is placed between the serial input `tdi` and the serial output `tdo`. The candidates are a 1-bit bypass cell, a 32-bit identification register and a boundary ring of `RING_W` cells. On a data capture, the boundary ring loads the parallel `ring_in` inputs. Two instructions also drive `hiz_force`, which tells the memory's output drivers to go to high impedance.

The controller has these states: reset (Test-Logic-Reset), idle (Run-Test/Idle), and two parallel branches for data (DR) and instruction (IR). Each branch has select, capture, shift, exit1, pause, exit2 and update states.

The transitions, written as (state, tms=0 / tms=1), are:

- reset: idle / reset
- idle: idle / DR-select
- DR-select: DR-capture / IR-select
- IR-select: IR-capture / reset
- capture: shift / exit1
- shift: shift / exit1
- exit1: pause / update
- pause: pause / exit2
- exit2: shift / update
- update: idle / DR-select

The capture, shift, exit1, pause, exit2 and update rows apply to both branches, each staying within its own branch.

The block only shifts and captures. The memory array, the pads and any parallel update of the boundary cells are outside it.

Top module: `scan_tap_ctrl`

## Requirements
- R1: While `trst_n` is low, the controller is held in reset, the instruction is IDCODE (001), and `hiz_force` and `tdo_en` are 0. The clear takes effect without waiting for a clock edge.
- R2: From any state, five rising edges with `tms` high reach the reset state. While in the reset state, the instruction register is loaded with IDCODE (001).
- R3: The state transitions are exactly the ones listed above. A data shift that is interrupted through exit1, pause and exit2 and then resumed loses no bit.
- R4: Capture-IR loads 001 into the instruction shifter. The shifter shifts out LSB first and takes `tdi` into its MSB. The new instruction takes effect only on the edge that leaves IR-update.
- R5: IDCODE (001) selects the 32-bit register. Capture-DR loads `ID_VALUE` into it, and it shifts out LSB first.
- R6: The codes 000, 010 and 100 select the boundary ring. Capture-DR loads `ring_in` into it, it shifts out LSB first, and `tdi` enters at the cell with the highest index.
- R7: BYPASS (111) selects a single cell that captures 0, which gives a one-cycle delay from `tdi` to `tdo`.
- R8: The reserved codes 011, 101 and 110 behave exactly like BYPASS, with `hiz_force` at 0.
- R9: `hiz_force` is 1 exactly when the current instruction is 000 or 010.
- R10: `tdo` and `tdo_en` change only on the falling edge of `tck`. `tdo_en` is 1 only in DR-shift and IR-shift.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| tms | input | 1 | Mode select, sampled on the rising edge |
| tdi | input | 1 | Serial data in |
| ring_in | input | RING_W | Parallel values captured by the boundary ring |
| tdo | output | 1 | Serial data out, updated on the falling edge |
| tdo_en | output | 1 | High while `tdo` carries shift data |
| hiz_force | output | 1 | Forces the memory outputs to high impedance |

## Verification
All eight instruction codes are loaded in turn. Each one is followed by a 40-bit data scan that uses a distinct `tdi` pattern and a distinct ring value. The point at which the captured bits give way to `tdi` bits reveals the length of the selected register, and the captured bits reveal the capture source. This distinguishes bypass, identification and ring, and shows reserved codes falling back to bypass. Further directed sequences cover three cases:

- a scan broken by a pause;
- an instruction shifted in but not yet updated;
- five high `tms` cycles taken from mid-scan.

Both asynchronous and synchronous resets are also exercised.

// File: rtl/scan_tap_pkg.sv
package scan_tap_pkg;

    localparam int unsigned IR_W = 3;
    localparam int unsigned ID_W = 32;

    typedef logic [IR_W-1:0] instr_t;

    localparam instr_t OP_EXTEST   = 3'b000;
    localparam instr_t OP_IDCODE   = 3'b001;
    localparam instr_t OP_SAMPLE_Z = 3'b010;
    localparam instr_t OP_SAMPLE   = 3'b100;
    localparam instr_t OP_BYPASS   = 3'b111;
    localparam instr_t IR_CAP_PAT  = 3'b001;

    typedef enum logic [3:0] {
        ST_RESET, ST_IDLE,
        ST_DR_SEL, ST_DR_CAP, ST_DR_SHIFT, ST_DR_EXIT1, ST_DR_PAUSE, ST_DR_EXIT2, ST_DR_UPD,
        ST_IR_SEL, ST_IR_CAP, ST_IR_SHIFT, ST_IR_EXIT1, ST_IR_PAUSE, ST_IR_EXIT2, ST_IR_UPD
    } tap_state_e;

    typedef enum logic [1:0] {PATH_BYPASS, PATH_ID, PATH_RING} dr_path_e;

    typedef struct packed {
        logic in_reset;
        logic cap_dr;
        logic sh_dr;
        logic cap_ir;
        logic sh_ir;
        logic upd_ir;
    } tap_ctl_t;

    function automatic dr_path_e path_of(instr_t op);
        case (op)
            OP_EXTEST, OP_SAMPLE_Z, OP_SAMPLE: return PATH_RING;
            OP_IDCODE:                         return PATH_ID;
            default:                           return PATH_BYPASS;
        endcase
    endfunction

    function automatic logic hiz_of(instr_t op);
        return (op == OP_EXTEST) || (op == OP_SAMPLE_Z);
    endfunction

endpackage

// File: rtl/tap_fsm.sv
module tap_fsm
    import scan_tap_pkg::*;
(
    input  logic       tck,
    input  logic       trst_n,
    input  logic       tms,
    output tap_state_e state_o,
    output tap_ctl_t   ctl_o
);

    tap_state_e state_q, state_d;

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) state_q <= ST_RESET;
        else         state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            ST_RESET:    state_d = tms ? ST_RESET    : ST_IDLE;
            ST_IDLE:     state_d = tms ? ST_DR_SEL   : ST_IDLE;
            ST_DR_SEL:   state_d = tms ? ST_IR_SEL   : ST_DR_CAP;
            ST_DR_CAP:   state_d = tms ? ST_DR_EXIT1 : ST_DR_SHIFT;
            ST_DR_SHIFT: state_d = tms ? ST_DR_EXIT1 : ST_DR_SHIFT;
            ST_DR_EXIT1: state_d = tms ? ST_DR_UPD   : ST_DR_PAUSE;
            ST_DR_PAUSE: state_d = tms ? ST_DR_EXIT2 : ST_DR_PAUSE;
            ST_DR_EXIT2: state_d = tms ? ST_DR_UPD   : ST_DR_SHIFT;
            ST_DR_UPD:   state_d = tms ? ST_DR_SEL   : ST_IDLE;
            ST_IR_SEL:   state_d = tms ? ST_RESET    : ST_IR_CAP;
            ST_IR_CAP:   state_d = tms ? ST_IR_EXIT1 : ST_IR_SHIFT;
            ST_IR_SHIFT: state_d = tms ? ST_IR_EXIT1 : ST_IR_SHIFT;
            ST_IR_EXIT1: state_d = tms ? ST_IR_UPD   : ST_IR_PAUSE;
            ST_IR_PAUSE: state_d = tms ? ST_IR_EXIT2 : ST_IR_PAUSE;
            ST_IR_EXIT2: state_d = tms ? ST_IR_UPD   : ST_IR_SHIFT;
            ST_IR_UPD:   state_d = tms ? ST_DR_SEL   : ST_IDLE;
        endcase
    end

    always_comb begin
        ctl_o          = '0;
        ctl_o.in_reset = (state_q == ST_RESET);
        ctl_o.cap_dr   = (state_q == ST_DR_CAP);
        ctl_o.sh_dr    = (state_q == ST_DR_SHIFT);
        ctl_o.cap_ir   = (state_q == ST_IR_CAP);
        ctl_o.sh_ir    = (state_q == ST_IR_SHIFT);
        ctl_o.upd_ir   = (state_q == ST_IR_UPD);
    end

    assign state_o = state_q;

endmodule

// File: rtl/tap_ir.sv
module tap_ir
    import scan_tap_pkg::*;
(
    input  logic     tck,
    input  logic     trst_n,
    input  logic     tdi,
    input  tap_ctl_t ctl,
    output instr_t   ir_o,
    output instr_t   ir_sh_o
);

    instr_t sh_q, cur_q;

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n)         sh_q <= IR_CAP_PAT;
        else if (ctl.cap_ir) sh_q <= IR_CAP_PAT;
        else if (ctl.sh_ir)  sh_q <= {tdi, sh_q[IR_W-1:1]};
    end

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n)           cur_q <= OP_IDCODE;
        else if (ctl.in_reset) cur_q <= OP_IDCODE;
        else if (ctl.upd_ir)   cur_q <= sh_q;
    end

    assign ir_o    = cur_q;
    assign ir_sh_o = sh_q;

endmodule

// File: rtl/tap_dr.sv
module tap_dr
    import scan_tap_pkg::*;
#(
    parameter logic [31:0] ID_VALUE = 32'h2B6E_40D3,
    parameter int unsigned RING_W   = 8
) (
    input  logic              tck,
    input  logic              trst_n,
    input  logic              tdi,
    input  tap_ctl_t          ctl,
    input  instr_t            instr,
    input  logic [RING_W-1:0] ring_in,
    output logic              dr_bit_o
);

    dr_path_e          path;
    logic              byp_q;
    logic [ID_W-1:0]   id_q;
    logic [RING_W-1:0] ring_q;

    assign path = path_of(instr);

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) byp_q <= 1'b0;
        else if (path == PATH_BYPASS) begin
            if (ctl.cap_dr)     byp_q <= 1'b0;
            else if (ctl.sh_dr) byp_q <= tdi;
        end
    end

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) id_q <= '0;
        else if (path == PATH_ID) begin
            if (ctl.cap_dr)     id_q <= ID_VALUE[ID_W-1:0];
            else if (ctl.sh_dr) id_q <= {tdi, id_q[ID_W-1:1]};
        end
    end

    generate
        if (RING_W == 1) begin : g_ring_one
            always_ff @(posedge tck or negedge trst_n) begin
                if (!trst_n) ring_q <= '0;
                else if (path == PATH_RING) begin
                    if (ctl.cap_dr)     ring_q <= ring_in;
                    else if (ctl.sh_dr) ring_q <= tdi;
                end
            end
        end else begin : g_ring_multi
            always_ff @(posedge tck or negedge trst_n) begin
                if (!trst_n) ring_q <= '0;
                else if (path == PATH_RING) begin
                    if (ctl.cap_dr)     ring_q <= ring_in;
                    else if (ctl.sh_dr) ring_q <= {tdi, ring_q[RING_W-1:1]};
                end
            end
        end
    endgenerate

    always_comb begin
        case (path)
            PATH_ID:   dr_bit_o = id_q[0];
            PATH_RING: dr_bit_o = ring_q[0];
            default:   dr_bit_o = byp_q;
        endcase
    end

endmodule

// File: rtl/tap_tdo.sv
module tap_tdo
    import scan_tap_pkg::*;
(
    input  logic     tck,
    input  logic     trst_n,
    input  tap_ctl_t ctl,
    input  logic     ir_bit,
    input  logic     dr_bit,
    output logic     tdo,
    output logic     tdo_en
);

    always_ff @(negedge tck or negedge trst_n) begin
        if (!trst_n) begin
            tdo    <= 1'b0;
            tdo_en <= 1'b0;
        end else begin
            tdo    <= ctl.sh_ir ? ir_bit : dr_bit;
            tdo_en <= ctl.sh_ir | ctl.sh_dr;
        end
    end

endmodule

// File: rtl/scan_tap_ctrl.sv
module scan_tap_ctrl
    import scan_tap_pkg::*;
#(
    parameter logic [31:0] ID_VALUE = 32'h2B6E_40D3,
    parameter int unsigned RING_W   = 8
) (
    input  logic              tck,
    input  logic              trst_n,
    input  logic              tms,
    input  logic              tdi,
    input  logic [RING_W-1:0] ring_in,
    output logic              tdo,
    output logic              tdo_en,
    output logic              hiz_force
);

    tap_state_e state_q;
    tap_ctl_t   ctl;
    instr_t     ir_q;
    instr_t     ir_sh;
    logic       dr_bit;

    tap_fsm u_fsm (
        .tck     (tck),
        .trst_n  (trst_n),
        .tms     (tms),
        .state_o (state_q),
        .ctl_o   (ctl)
    );

    tap_ir u_ir (
        .tck     (tck),
        .trst_n  (trst_n),
        .tdi     (tdi),
        .ctl     (ctl),
        .ir_o    (ir_q),
        .ir_sh_o (ir_sh)
    );

    tap_dr #(.ID_VALUE(ID_VALUE), .RING_W(RING_W)) u_dr (
        .tck      (tck),
        .trst_n   (trst_n),
        .tdi      (tdi),
        .ctl      (ctl),
        .instr    (ir_q),
        .ring_in  (ring_in),
        .dr_bit_o (dr_bit)
    );

    tap_tdo u_tdo (
        .tck    (tck),
        .trst_n (trst_n),
        .ctl    (ctl),
        .ir_bit (ir_sh[0]),
        .dr_bit (dr_bit),
        .tdo    (tdo),
        .tdo_en (tdo_en)
    );

    assign hiz_force = hiz_of(ir_q);

endmodule

// File: rtl/scan_tap_chk.sv
module scan_tap_chk
    import scan_tap_pkg::*;
(
    input logic       tck,
    input logic       trst_n,
    input logic       tms,
    input tap_state_e state_q,
    input instr_t     ir_q,
    input instr_t     ir_sh,
    input logic       tdo_en,
    input logic       hiz_force
);

    logic [2:0] ones_q;

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n)        ones_q <= '0;
        else if (!tms)      ones_q <= '0;
        else if (ones_q < 5) ones_q <= ones_q + 3'd1;
    end

    AST_FIVE_HIGH_RESETS: assert property (@(posedge tck) disable iff (!trst_n)
        (ones_q == 3'd5) |-> (state_q == ST_RESET)); // R2

    AST_RESET_LOADS_IDCODE: assert property (@(posedge tck) disable iff (!trst_n)
        (state_q == ST_RESET) |=> (ir_q == OP_IDCODE)); // R2

    AST_CAPIR_PATTERN: assert property (@(posedge tck) disable iff (!trst_n)
        (state_q == ST_IR_CAP) |=> (ir_sh == IR_CAP_PAT)); // R4

    AST_HIZ_ONLY_ON_UPDATE: assert property (@(posedge tck) disable iff (!trst_n)
        (state_q != ST_IR_UPD && state_q != ST_RESET) |=> $stable(hiz_force)); // R9

    AST_TDO_EN_SHIFT_ONLY: assert property (@(posedge tck) disable iff (!trst_n)
        tdo_en |-> (state_q == ST_DR_SHIFT || state_q == ST_IR_SHIFT)); // R10

    AST_SHIFT_DRIVES_EN: assert property (@(posedge tck) disable iff (!trst_n)
        (state_q == ST_DR_SHIFT || state_q == ST_IR_SHIFT) |-> tdo_en); // R10

endmodule

bind scan_tap_ctrl scan_tap_chk u_chk (
    .tck       (tck),
    .trst_n    (trst_n),
    .tms       (tms),
    .state_q   (state_q),
    .ir_q      (ir_q),
    .ir_sh     (ir_sh),
    .tdo_en    (tdo_en),
    .hiz_force (hiz_force)
);

// File: tb/scan_tap_ctrl_tb.sv
module scan_tap_ctrl_tb;

    localparam logic [31:0] ID   = 32'h2B6E_40D3;
    localparam int          RW   = 8;
    localparam int          SCAN = 40;

    typedef struct packed {
        logic [2:0]  ins;
        logic [7:0]  ring;
        logic [5:0]  len;
        logic [39:0] cap;
        logic        hiz;
        logic [39:0] pat;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{3'b000, 8'hA5, 6'd8,  40'hA5,      1'b1, 40'hC3_9A5E_1B7D},
        '{3'b001, 8'h00, 6'd32, {8'h0, ID},  1'b0, 40'h5A_0F3C_E1D2},
        '{3'b010, 8'h3C, 6'd8,  40'h3C,      1'b1, 40'h96_1E2D_4B87},
        '{3'b100, 8'hC3, 6'd8,  40'hC3,      1'b0, 40'h0F_F00F_A55A},
        '{3'b111, 8'hFF, 6'd1,  40'h0,       1'b0, 40'hB7_6D24_9E13},
        '{3'b011, 8'hFF, 6'd1,  40'h0,       1'b0, 40'h3D_C852_7A61},
        '{3'b101, 8'hFF, 6'd1,  40'h0,       1'b0, 40'hE4_1B97_0C2F},
        '{3'b110, 8'hFF, 6'd1,  40'h0,       1'b0, 40'h71_A3F6_58D9}
    };

    logic          tck = 1'b0;
    logic          trst_n = 1'b0;
    logic          tms = 1'b1;
    logic          tdi = 1'b0;
    logic [RW-1:0] ring_in = '0;
    logic          tdo, tdo_en, hiz_force;

    int total = 0;
    int fails = 0;

    scan_tap_ctrl #(.ID_VALUE(ID), .RING_W(RW)) u_dut (
        .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .ring_in(ring_in),
        .tdo(tdo), .tdo_en(tdo_en), .hiz_force(hiz_force)
    );

    always #2 tck = ~tck;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step(input logic tms_v, input logic tdi_v, output logic tdo_s, output logic en_s);
        tms = tms_v;
        tdi = tdi_v;
        @(negedge tck); #1;
        tdo_s = tdo;
        en_s  = tdo_en;
        @(posedge tck); #1;
    endtask

    task automatic go(input logic tms_v);
        logic o, e;
        step(tms_v, 1'b0, o, e);
    endtask

    task automatic ir_scan(input logic [2:0] ins, output logic [2:0] cap);
        logic o, e;
        go(1); go(1); go(0); go(0);
        for (int i = 0; i < 3; i++) begin
            step(i == 2, ins[i], o, e);
            cap[i] = o;
        end
        go(1); go(0);
    endtask

    task automatic dr_scan(input int n, input logic [63:0] din, output logic [63:0] dout, output logic en_all);
        logic o, e;
        dout   = '0;
        en_all = 1'b1;
        go(1); go(0); go(0);
        for (int i = 0; i < n; i++) begin
            step(i == n - 1, din[i], o, e);
            dout[i] = o;
            en_all &= e;
        end
        go(1); go(0);
    endtask

    function automatic logic [39:0] model(input int len, input logic [39:0] cap, input logic [39:0] pat);
        return (cap & ((40'd1 << len) - 40'd1)) | (pat << len);
    endfunction

    function automatic string req_of(input logic [2:0] ins);
        case (ins)
            3'b001:                 return "R5";
            3'b000, 3'b010, 3'b100: return "R6";
            3'b111:                 return "R7";
            default:                return "R8";
        endcase
    endfunction

    initial begin
        #800000;
        fails++;
        total++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        logic [63:0] dout;
        logic [2:0]  cap;
        logic        en, o, e;

        // R1: reset state
        #7;
        chk("R1 hiz in reset", hiz_force, 0);
        chk("R1 tdo_en in reset", tdo_en, 0);
        trst_n = 1'b1;
        @(posedge tck); #1;
        go(0);
        dr_scan(32, 64'h0, dout, en);
        chk("R1 IDCODE after reset", dout[31:0], ID);

        // Table walk over all instruction codes
        for (int r = 0; r < 8; r++) begin
            ir_scan(VECS[r].ins, cap);
            chk("R4 capture-IR pattern", cap, 3'b001);
            chk("R9 hiz per instruction", hiz_force, VECS[r].hiz);
            ring_in = VECS[r].ring;
            dr_scan(SCAN, {24'h0, VECS[r].pat}, dout, en);
            chk(req_of(VECS[r].ins), dout[39:0], model(int'(VECS[r].len), VECS[r].cap, VECS[r].pat));
            chk("R10 tdo_en during shift", en, 1);
            chk("R10 tdo_en in idle", tdo_en, 0);
        end

        // R4: instruction takes effect only on leaving IR-update
        ir_scan(3'b000, cap);
        go(1); go(1); go(0); go(0);
        step(0, 1, o, e); step(0, 1, o, e); step(1, 1, o, e);
        chk("R4 hiz held in exit1", hiz_force, 1);
        go(1);
        chk("R4 hiz held in update", hiz_force, 1);
        go(0);
        chk("R4 hiz after update", hiz_force, 0);

        // R2: five high TMS cycles from mid-scan
        ir_scan(3'b010, cap);
        chk("R9 SAMPLE-Z hiz", hiz_force, 1);
        go(1); go(0); go(0);
        for (int k = 0; k < 6; k++) go(1);
        chk("R2 hiz cleared by reset state", hiz_force, 0);
        go(0);
        dr_scan(32, 64'h0, dout, en);
        chk("R2 IDCODE after tms reset", dout[31:0], ID);

        // R3: pause in the middle of an ID scan
        go(1); go(0); go(0);
        chk("R10 tdo_en low before falling edge", tdo_en, 0);
        dout = '0;
        for (int i = 0; i < 16; i++) begin
            step(i == 15, 1'b0, o, e);
            dout[i] = o;
        end
        step(0, 0, o, e);
        chk("R10 tdo_en low in exit1", e, 0);
        go(0); go(1); go(0);
        for (int i = 16; i < 32; i++) begin
            step(i == 31, 1'b0, o, e);
            dout[i] = o;
        end
        go(1); go(0);
        chk("R3 scan across pause", dout[31:0], ID);

        // R1: asynchronous reset mid-run
        ir_scan(3'b000, cap);
        chk("R9 EXTEST hiz", hiz_force, 1);
        trst_n = 1'b0;
        #1;
        chk("R1 async clear of hiz", hiz_force, 0);
        trst_n = 1'b1;

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule